// File: doc/BRIEF.md
# Serial Port Status Flag Unit

This block holds the status flags of an asynchronous serial port. On the receive side it keeps a receive-full flag, a parity-error flag and the most recent multiprocessor bit. It also holds the receive data register. On the transmit side it keeps a transmit-data-empty flag and a transmit-end flag. The receive and transmit shifters report frame events to it. The CPU reads the status and clears flags through a small strobe port. A DMA write strobe marks a transfer into the transmit data register.

Software may clear a clearable flag only in two steps. It reads the status while the flag is 1, and then writes 0 to that flag's bit. A frame that fails its parity check is still captured, but it never raises receive-full. Further reception stops until the parity-error flag is cleared. Transmit-end follows the transmit-empty state at the moment the final bit of a character leaves the shifter.

Top module: `sci_status_flags`

## Requirements
- R1: With parity enabled, a received frame sets `par_err` when the XOR of all data bits and `rx_par_bit` differs from `par_odd` (0 selects even, 1 selects odd). With parity disabled, no frame sets it.
- R2: The write field `stat_wdata` places receive-full at bit 0, transmit-empty at bit 1 and parity-error at bit 2. A flag is cleared only by a `stat_wr` that carries 0 in its bit, and only after a `stat_rd` that found the flag at 1. Each write uses up the arming from the read, and a write of 1 never clears a flag.
- R3: A frame that fails parity is loaded into `rdr_data`, but `rdr_full` is not set.
- R4: While `par_err` is 1, `rx_halt` is 1 and incoming frames change neither `rdr_data` nor any receive flag.
- R5: While `rx_en` is 0, frames are ignored, and `par_err` and `mp_flag` keep their values.
- R6: When `mp_mode` is 1, each accepted frame copies `rx_mp_bit` into `mp_flag`. When `mp_mode` is 0, `mp_flag` is left unchanged.
- R7: `tx_end` is set whenever `tx_en` is 0. It is also set on `tx_last_bit` when `tdr_empty` is 1, but not when `tdr_empty` is 0.
- R8: `tdr_empty` and `tx_end` are both cleared by a qualified software clear of transmit-empty or by `dma_tdr_wr`.
- R9: `tx_end` and `mp_flag` have no bit in the write field, so a status write that keeps bit 1 at 1 leaves both unchanged.
- R10: After reset, `tdr_empty` and `tx_end` are 1. `par_err`, `rdr_full`, `mp_flag`, `rx_halt` and `rdr_data` are 0.
- R11: When a set event and a clear arrive in the same cycle, the flag ends up set.
- R12: `tx_load`, which marks the shifter taking the transmit data, sets `tdr_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| tx_en | input | 1 | Transmitter enable |
| par_en | input | 1 | Parity check enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| mp_mode | input | 1 | Multiprocessor frame format |
| rx_frame_done | input | 1 | Received frame complete strobe |
| rx_data | input | DATA_W | Received data byte |
| rx_par_bit | input | 1 | Received parity bit |
| rx_mp_bit | input | 1 | Received multiprocessor bit |
| tx_load | input | 1 | Transmit shifter took the data register |
| tx_last_bit | input | 1 | Last bit of a character is being sent |
| dma_tdr_wr | input | 1 | DMA write into the transmit data register |
| stat_rd | input | 1 | CPU status read strobe |
| stat_wr | input | 1 | CPU status write strobe |
| stat_wdata | input | 3 | Write field for the clearable flags |
| rdr_data | output | DATA_W | Receive data register |
| rdr_full | output | 1 | Receive data full |
| tdr_empty | output | 1 | Transmit data empty |
| par_err | output | 1 | Parity error |
| tx_end | output | 1 | Transmission ended |
| mp_flag | output | 1 | Last multiprocessor bit received |
| rx_halt | output | 1 | Reception blocked |

## Verification
The assertions run on every cycle. They check the following:
- A parity failure never raises receive-full.
- The receive register holds while reception is halted.
- The multiprocessor flag holds while the receiver is off.
- A disabled transmitter forces transmit-end.
- Transmit-end and parity-error fall only after a matching clear cause.
- Set events win over same-cycle clears.

Only the bench scenarios can show the two-step clear sequence itself: a write without a read, a write of 1, and a second write after one read. The scenarios also cover the parity arithmetic across even, odd and disabled settings, and the exact values stored from a sequence of frames.

// File: rtl/sci_flags_pkg.sv
package sci_flags_pkg;
  // Bit positions of the clearable flags in the status write field.
  localparam int CLR_W    = 3;
  localparam int BIT_FULL = 0;
  localparam int BIT_TDRE = 1;
  localparam int BIT_PER  = 2;
endpackage

// File: rtl/sci_clr_arm.sv
// Per-flag arming: a status read records which flags were 1; the next
// status write may clear only those, and it consumes the arming.
module sci_clr_arm #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] flags,
  output logic [N-1:0] clr
);
  for (genvar i = 0; i < N; i++) begin : g_arm
    logic armed_q, armed_d;

    always_comb begin
      armed_d = armed_q;
      if (wr) armed_d = 1'b0;
      if (rd) armed_d = flags[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= armed_d;
    end

    assign clr[i] = wr & armed_q & ~wdata[i];
  end
endmodule

// File: rtl/sci_rx_flags.sv
module sci_rx_flags #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mp_mode,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] data,
  input  logic              par_bit,
  input  logic              mp_bit,
  input  logic              clr_full,
  input  logic              clr_per,
  output logic [DATA_W-1:0] rdr,
  output logic              full,
  output logic              per,
  output logic              mpb
);
  logic              full_q, full_d;
  logic              per_q, per_d;
  logic              mpb_q, mpb_d;
  logic [DATA_W-1:0] rdr_q;
  logic              accept, bad;

  assign accept = frame_done & rx_en & ~per_q;
  assign bad    = par_en & ((^{data, par_bit}) != par_odd);

  always_comb begin
    per_d  = per_q;
    full_d = full_q;
    mpb_d  = mpb_q;
    if (clr_per)         per_d  = 1'b0;
    if (clr_full)        full_d = 1'b0;
    if (accept && bad)   per_d  = 1'b1;
    if (accept && !bad)  full_d = 1'b1;
    if (accept && mp_mode) mpb_d = mp_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= 1'b0;
      full_q <= 1'b0;
      mpb_q  <= 1'b0;
    end else begin
      per_q  <= per_d;
      full_q <= full_d;
      mpb_q  <= mpb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdr_q <= '0;
    else if (accept) rdr_q <= data;
  end

  assign rdr  = rdr_q;
  assign full = full_q;
  assign per  = per_q;
  assign mpb  = mpb_q;

  AST_PER_NO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(per_q) |-> !$rose(full_q)); // R3
  AST_HALT_HOLDS_RDR: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && per_q) |=> $stable(rdr_q)); // R4
  AST_RXOFF_MPB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(mpb_q)); // R5
  AST_FULL_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && rx_en && !per_q && !bad && clr_full) |=> full_q); // R11
endmodule

// File: rtl/sci_tx_flags.sv
module sci_tx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic tx_load,
  input  logic tx_last_bit,
  input  logic dma_wr,
  input  logic clr_tdre,
  output logic tdre,
  output logic tend
);
  logic tdre_q, tdre_d;
  logic tend_q, tend_d;
  logic tdr_clr;

  assign tdr_clr = clr_tdre | dma_wr;

  always_comb begin
    tdre_d = tdre_q;
    tend_d = tend_q;
    if (tdr_clr) begin
      tdre_d = 1'b0;
      tend_d = 1'b0;
    end
    if (tx_load) tdre_d = 1'b1;
    if (!tx_en || (tx_last_bit && tdre_q)) tend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdre_q <= 1'b1;
      tend_q <= 1'b1;
    end else begin
      tdre_q <= tdre_d;
      tend_q <= tend_d;
    end
  end

  assign tdre = tdre_q;
  assign tend = tend_q;

  AST_TEND_TXOFF: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> tend_q); // R7
  AST_TEND_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tend_q) |-> $past(dma_wr || clr_tdre)); // R8
  AST_TDRE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> tdre_q); // R11
endmodule

// File: rtl/sci_status_flags.sv
module sci_status_flags
  import sci_flags_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mp_mode,
  input  logic              rx_frame_done,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_par_bit,
  input  logic              rx_mp_bit,
  input  logic              tx_load,
  input  logic              tx_last_bit,
  input  logic              dma_tdr_wr,
  input  logic              stat_rd,
  input  logic              stat_wr,
  input  logic [2:0]        stat_wdata,
  output logic [DATA_W-1:0] rdr_data,
  output logic              rdr_full,
  output logic              tdr_empty,
  output logic              par_err,
  output logic              tx_end,
  output logic              mp_flag,
  output logic              rx_halt
);
  // Reset: asserted asynchronously, released on the second clock edge.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [CLR_W-1:0] flag_vec, clr_vec;
  logic             full_w, tdre_w, per_w;

  always_comb begin
    flag_vec           = '0;
    flag_vec[BIT_FULL] = full_w;
    flag_vec[BIT_TDRE] = tdre_w;
    flag_vec[BIT_PER]  = per_w;
  end

  sci_clr_arm #(.N(CLR_W)) u_arm (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rd    (stat_rd),
    .wr    (stat_wr),
    .wdata (stat_wdata),
    .flags (flag_vec),
    .clr   (clr_vec)
  );

  sci_rx_flags #(.DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .rx_en      (rx_en),
    .par_en     (par_en),
    .par_odd    (par_odd),
    .mp_mode    (mp_mode),
    .frame_done (rx_frame_done),
    .data       (rx_data),
    .par_bit    (rx_par_bit),
    .mp_bit     (rx_mp_bit),
    .clr_full   (clr_vec[BIT_FULL]),
    .clr_per    (clr_vec[BIT_PER]),
    .rdr        (rdr_data),
    .full       (full_w),
    .per        (per_w),
    .mpb        (mp_flag)
  );

  sci_tx_flags u_tx (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tx_en       (tx_en),
    .tx_load     (tx_load),
    .tx_last_bit (tx_last_bit),
    .dma_wr      (dma_tdr_wr),
    .clr_tdre    (clr_vec[BIT_TDRE]),
    .tdre        (tdre_w),
    .tend        (tx_end)
  );

  assign rdr_full  = full_w;
  assign tdr_empty = tdre_w;
  assign par_err   = per_w;
  assign rx_halt   = per_w;

  AST_PER_CLR_QUAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(par_err) |-> $past(stat_wr && !stat_wdata[BIT_PER])); // R2
  AST_FULL_CLR_QUAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(rdr_full) |-> $past(stat_wr && !stat_wdata[BIT_FULL])); // R2
endmodule

// File: tb/sci_status_flags_tb_top.sv
`timescale 1ns/1ps
module sci_status_flags_tb_top;
  logic       clk, rst_n;
  logic       rx_en, tx_en, par_en, par_odd, mp_mode;
  logic       rx_frame_done, rx_par_bit, rx_mp_bit;
  logic [7:0] rx_data;
  logic       tx_load, tx_last_bit, dma_tdr_wr;
  logic       stat_rd, stat_wr;
  logic [2:0] stat_wdata;
  logic [7:0] rdr_data;
  logic       rdr_full, tdr_empty, par_err, tx_end, mp_flag, rx_halt;

  int checks = 0;
  int fails  = 0;

  sci_status_flags #(.DATA_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .tx_en(tx_en),
    .par_en(par_en), .par_odd(par_odd), .mp_mode(mp_mode),
    .rx_frame_done(rx_frame_done), .rx_data(rx_data),
    .rx_par_bit(rx_par_bit), .rx_mp_bit(rx_mp_bit),
    .tx_load(tx_load), .tx_last_bit(tx_last_bit), .dma_tdr_wr(dma_tdr_wr),
    .stat_rd(stat_rd), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .rdr_data(rdr_data), .rdr_full(rdr_full), .tdr_empty(tdr_empty),
    .par_err(par_err), .tx_end(tx_end), .mp_flag(mp_flag), .rx_halt(rx_halt)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Fields: [15:8] data, [7] parity bit, [6] parity enable, [5] odd,
  // [4] mp mode, [3] mp bit, [2] exp par_err, [1] exp full, [0] exp mp_flag
  localparam logic [15:0] VEC [0:8] = '{
    16'hA542, 16'hA5C4, 16'h0162, 16'h01E4, 16'h3C9B,
    16'h7FD2, 16'hFF5B, 16'h8063, 16'h805D
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [7:0] d, input logic pb, input logic pen,
                       input logic podd, input logic mpm, input logic mpb);
    @(negedge clk);
    rx_data = d; rx_par_bit = pb; par_en = pen; par_odd = podd;
    mp_mode = mpm; rx_mp_bit = mpb; rx_frame_done = 1'b1;
    @(negedge clk);
    rx_frame_done = 1'b0;
  endtask

  task automatic sw_read();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic sw_write(input logic [2:0] w);
    @(negedge clk); stat_wr = 1'b1; stat_wdata = w;
    @(negedge clk); stat_wr = 1'b0;
  endtask

  task automatic pulse_tx(input logic ld, input logic lb, input logic dm);
    @(negedge clk); tx_load = ld; tx_last_bit = lb; dma_tdr_wr = dm;
    @(negedge clk); tx_load = 1'b0; tx_last_bit = 1'b0; dma_tdr_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; tx_en = 1'b0; par_en = 1'b0; par_odd = 1'b0;
    mp_mode = 1'b0; rx_frame_done = 1'b0; rx_data = '0; rx_par_bit = 1'b0;
    rx_mp_bit = 1'b0; tx_load = 1'b0; tx_last_bit = 1'b0; dma_tdr_wr = 1'b0;
    stat_rd = 1'b0; stat_wr = 1'b0; stat_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10 tdr_empty", tdr_empty, 1);
    chk("R10 tx_end", tx_end, 1);
    chk("R10 par_err", par_err, 0);
    chk("R10 rdr_full", rdr_full, 0);
    chk("R10 mp_flag", mp_flag, 0);
    chk("R10 rx_halt", rx_halt, 0);
    chk("R10 rdr_data", rdr_data, 0);
    rx_en = 1'b1; tx_en = 1'b1;

    // Vector walk: R1 parity, R3 stored data, R6 multiprocessor bit
    for (int i = 0; i < 9; i++) begin
      frame(VEC[i][15:8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
      chk("R1 par_err", par_err, VEC[i][2]);
      chk("R3 rdr_full", rdr_full, VEC[i][1]);
      chk("R3 rdr_data", rdr_data, VEC[i][15:8]);
      chk("R6 mp_flag", mp_flag, VEC[i][0]);
      chk("R4 rx_halt", rx_halt, VEC[i][2]);
      sw_read(); sw_write(3'b000);
      chk("R2 clear all", {par_err, rdr_full}, 0);
    end

    // R4: halted reception ignores frames
    frame(8'h11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R1 par_err set", par_err, 1);
    frame(8'h22, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R4 rdr_data held", rdr_data, 8'h11);
    chk("R4 rdr_full low", rdr_full, 0);
    chk("R4 rx_halt", rx_halt, 1);

    // R2: qualified clear sequence
    sw_write(3'b000);
    chk("R2 write without read", par_err, 1);
    sw_read(); sw_write(3'b100);
    chk("R2 write of one", par_err, 1);
    sw_write(3'b000);
    chk("R2 arming consumed", par_err, 1);
    sw_read(); sw_write(3'b000);
    chk("R2 qualified clear", par_err, 0);

    // R5: receiver off
    rx_en = 1'b0;
    frame(8'h33, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R5 par_err held", par_err, 0);
    chk("R5 mp_flag held", mp_flag, 1);
    chk("R5 rdr_data held", rdr_data, 8'h11);
    rx_en = 1'b1;

    // R11: frame and clear write in the same cycle
    frame(8'h44, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3 good frame full", rdr_full, 1);
    sw_read();
    @(negedge clk);
    stat_wr = 1'b1; stat_wdata = 3'b000;
    rx_data = 8'h55; rx_par_bit = 1'b0; rx_frame_done = 1'b1;
    @(negedge clk);
    stat_wr = 1'b0; rx_frame_done = 1'b0;
    chk("R11 full set wins", rdr_full, 1);
    chk("R11 rdr_data", rdr_data, 8'h55);
    sw_read(); sw_write(3'b000);

    // Transmit side (tdr_empty and tx_end are 0 here)
    chk("R8 state entering tx", {tdr_empty, tx_end}, 0);
    pulse_tx(1'b1, 1'b0, 1'b0);
    chk("R12 tx_load sets tdr_empty", tdr_empty, 1);
    chk("R7 tx_end stays low", tx_end, 0);
    pulse_tx(1'b0, 1'b0, 1'b1);
    chk("R8 dma clears", {tdr_empty, tx_end}, 0);
    pulse_tx(1'b0, 1'b1, 1'b0);
    chk("R7 last bit with data pending", tx_end, 0);
    pulse_tx(1'b1, 1'b0, 1'b0);
    pulse_tx(1'b0, 1'b1, 1'b0);
    chk("R7 last bit when empty", tx_end, 1);
    sw_read(); sw_write(3'b010);
    chk("R9 tx_end unaffected", tx_end, 1);
    chk("R9 mp_flag unaffected", mp_flag, 1);
    chk("R9 tdr_empty kept", tdr_empty, 1);
    sw_read(); sw_write(3'b000);
    chk("R8 software clear", {tdr_empty, tx_end}, 0);
    pulse_tx(1'b1, 1'b0, 1'b1);
    chk("R11 load beats dma", tdr_empty, 1);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R7 tx disabled", tx_end, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule